// File: doc/BRIEF.md
# Four-Channel Cascadable Interval Timer

This block contains four 16-bit up-counters that share one register bus. Each channel has a reload value, a control halfword and a live count. A free-running channel advances once per prescaled period. The period is 1, 64, 256 or 1024 clocks. When the count passes 0xFFFF, the channel restarts from its reload value. A channel in chained mode ignores its prescaler and instead advances once for every wrap of the channel just below it. A chained channel rolls over to zero and does not reload. A single cycle can therefore ripple a wrap up through several chained channels.

Software writes one 32-bit word per channel. The low half sets the reload value and the high half sets the control. A combinational read of the selected channel returns the control halfword and the current count. On a wrap, each channel can latch an interrupt flag. That flag stays set until a clear pulse arrives on the channel's own clear input. Channels 0 and 1 also drive a one-cycle strobe toward an audio sampler.

Top module: `quad_interval_timer`

## Requirements
- R1: After reset, every count, reload value and control halfword is zero, every interrupt flag is low and both audio strobes are low.
- R2: With the run bit (control bit 7) set and the chain bit (control bit 2) clear, a channel adds one each period. The period is set by the rate field in control bits [1:0]: 0→1, 1→64, 2→256, 3→1024 clocks.
- R3: A write places bus data [15:0] in the reload register and [31:16] in the control register. A read returns {control, count} for the channel on the address lines. Control bits that have no function read back as written.
- R4: The count is loaded from the written reload value only in a write that changes the run bit from 0 to 1. A write to a channel that is already running leaves its count unchanged, even when the reload value changes.
- R5: When a free-running channel advances from 0xFFFF, it loads its current reload value in that same edge and keeps counting.
- R6: A chained channel n (n≥1) adds one on each cycle in which channel n-1 wraps. Channel 0 never advances while in chained mode.
- R7: A chained channel that advances from 0xFFFF becomes 0, not its reload value. Its wrap counts as an overflow in the same cycle, so it can advance the next chained channel at that same edge.
- R8: While the run bit is clear, or while a chained channel receives no wrap from below, the count holds and reads back unchanged.
- R9: A wrap with control bit 6 (interrupt enable) set sets that channel's interrupt flag at the same edge. A wrap with bit 6 clear leaves the flag alone.
- R10: A pulse on a channel's clear input clears its flag at the next edge. If a wrap with interrupt enable set occurs in the same cycle, the flag stays set.
- R11: Audio strobe k (k = 0, 1) is high for exactly the one cycle after the edge at which channel k wraps.
- R12: The prescaler restarts from zero when the run bit rises and whenever a write changes the rate field. The first step after that comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for the addressed channel |
| bus_addr | input | 2 | Channel select for reads and writes |
| bus_wdata | input | 32 | {control, reload} write data |
| bus_rdata | output | 32 | {control, count} of the addressed channel |
| irq_clr | input | 4 | Per-channel flag clear pulses |
| irq_flag | output | 4 | Per-channel interrupt flags |
| audio_stb | output | 2 | Wrap strobes of channels 0 and 1 |

## Verification
Every stored result shows up at the first edge after the cycle that caused it: a write, a prescaler step, a wrap (including a chained ripple), a flag set or clear, and an audio strobe. The read data is combinational on the address, so it follows the address within the same cycle. The bench drives inputs and samples outputs on the falling edge. Its reference model advances once per rising edge, using the inputs that were present before that edge, and its state is compared at the next falling edge. The directed checks count edges exactly from each write: for example, 64 edges until the first step at rate 1, and two edges until a wrap ripples through two chained channels.

// File: rtl/qit_pkg.sv
package qit_pkg;

    localparam int QIT_CTRL_W = 16;
    localparam int QIT_PSC_W  = 10;

    // Control halfword; the position of each field is visible to software.
    typedef struct packed {
        logic [7:0] spare_hi;   // [15:8] stored only
        logic       run;        // [7]
        logic       irq_en;     // [6]
        logic [2:0] spare_mid;  // [5:3] stored only
        logic       chain;      // [2]
        logic [1:0] rate;       // [1:0]
    } qit_ctrl_t;

    // Last prescaler phase for each rate code (period minus one).
    function automatic logic [QIT_PSC_W-1:0] qit_last_phase(input logic [1:0] rate);
        logic [QIT_PSC_W-1:0] last;
        unique case (rate)
            2'd0:    last = QIT_PSC_W'(0);
            2'd1:    last = QIT_PSC_W'(63);
            2'd2:    last = QIT_PSC_W'(255);
            default: last = QIT_PSC_W'(1023);
        endcase
        return last;
    endfunction

endpackage

// File: rtl/qit_prescaler.sv
module qit_prescaler
    import qit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] rate,
    output logic       tick
);

    typedef struct packed {
        logic [QIT_PSC_W-1:0] phase;
    } psc_state_t;

    psc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        tick    = run && (state_q.phase == qit_last_phase(rate));
        if (run) begin
            state_d.phase = tick ? '0 : state_q.phase + 1'b1;
        end
        if (clear) begin
            state_d.phase = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R2: at any rate other than 0, two steps never fall on adjacent cycles
    a_r2_no_adjacent_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate != 2'd0) |=> (!tick || rate == 2'd0));

    // R12: after a clear, the next cycle cannot step unless the rate is 0
    a_r12_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && rate != 2'd0) |=> (!tick || rate == 2'd0));

endmodule

// File: rtl/qit_channel.sv
module qit_channel
    import qit_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int WORD_W = CNT_W + QIT_CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              irq_clr,
    input  logic              prev_ovf,
    output logic [CNT_W-1:0]  count_o,
    output qit_ctrl_t         ctrl_o,
    output logic              ovf_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        qit_ctrl_t        ctrl;
        logic             irq;
    } chan_state_t;

    chan_state_t state_d, state_q;

    qit_ctrl_t wr_ctrl;
    logic      run_rise;
    logic      rate_change;
    logic      psc_tick;
    logic      step;
    logic      wrap;

    assign wr_ctrl     = qit_ctrl_t'(wdata[WORD_W-1:CNT_W]);
    assign run_rise    = wr_en && !state_q.ctrl.run && wr_ctrl.run;
    assign rate_change = wr_en && (wr_ctrl.rate != state_q.ctrl.rate);

    qit_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q.ctrl.run && !state_q.ctrl.chain),
        .clear (run_rise || rate_change),
        .rate  (state_q.ctrl.rate),
        .tick  (psc_tick)
    );

    always_comb begin
        state_d = state_q;
        step    = state_q.ctrl.run && (state_q.ctrl.chain ? prev_ovf : psc_tick);
        wrap    = step && (&state_q.count);

        if (wrap) begin
            state_d.count = state_q.ctrl.chain ? '0 : state_q.reload;
        end else if (step) begin
            state_d.count = state_q.count + 1'b1;
        end

        state_d.irq = (state_q.irq && !irq_clr) || (wrap && state_q.ctrl.irq_en);

        if (wr_en) begin
            state_d.reload = wdata[CNT_W-1:0];
            state_d.ctrl   = wr_ctrl;
            if (run_rise) begin
                state_d.count = wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;
    assign ctrl_o  = state_q.ctrl;
    assign ovf_o   = wrap;
    assign irq_o   = state_q.irq;

    // R5: a free-running wrap restarts from the reload value held before the edge
    a_r5_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !state_q.ctrl.chain && !wr_en) |=> (state_q.count == $past(state_q.reload)));

    // R7: a chained wrap lands on zero
    a_r7_chain_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && state_q.ctrl.chain && !wr_en) |=> (state_q.count == '0));

    // R8: a stopped channel keeps its count
    a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.ctrl.run && !wr_en) |=> $stable(state_q.count));

    // R8: a chained channel with no wrap from below keeps its count
    a_r8_hold_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctrl.chain && !prev_ovf && !wr_en) |=> $stable(state_q.count));

    // R4: rewriting a running channel does not reload it
    a_r4_no_reload_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state_q.ctrl.run && !step) |=> $stable(state_q.count));

    // R10: a set flag survives any cycle without a clear pulse
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.irq && !irq_clr) |=> state_q.irq);

endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
    import qit_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int CNT_W      = 16,
    parameter int AUDIO_TAPS = 2,
    localparam int ADDR_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    localparam int WORD_W = CNT_W + QIT_CTRL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [NUM_TIMERS-1:0] irq_clr,
    output logic [NUM_TIMERS-1:0] irq_flag,
    output logic [AUDIO_TAPS-1:0] audio_stb
);

    typedef struct packed {
        logic [AUDIO_TAPS-1:0] audio;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [CNT_W-1:0]      count_w [NUM_TIMERS];
    qit_ctrl_t             ctrl_w  [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] ovf_w;
    logic [NUM_TIMERS-1:0] prev_w;

    generate
        for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
            if (i == 0) begin : g_head
                assign prev_w[i] = 1'b0;
            end else begin : g_link
                assign prev_w[i] = ovf_w[i-1];

                // R7: a wrap ripples through a chained channel in the same cycle
                a_r7_chain_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                    (ovf_w[i-1] && ctrl_w[i].run && ctrl_w[i].chain && (&count_w[i])) |-> ovf_w[i]);
            end

            qit_channel #(.CNT_W(CNT_W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (bus_wr_en && (bus_addr == ADDR_W'(i))),
                .wdata    (bus_wdata),
                .irq_clr  (irq_clr[i]),
                .prev_ovf (prev_w[i]),
                .count_o  (count_w[i]),
                .ctrl_o   (ctrl_w[i]),
                .ovf_o    (ovf_w[i]),
                .irq_o    (irq_flag[i])
            );

            // R9: a wrap with interrupt enable raises the flag at the next edge
            a_r9_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf_w[i] && ctrl_w[i].irq_en) |=> irq_flag[i]);
        end
    endgenerate

    always_comb begin
        top_d       = top_q;
        top_d.audio = ovf_w[AUDIO_TAPS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign audio_stb = top_q.audio;
    assign bus_rdata = {ctrl_w[bus_addr], count_w[bus_addr]};

    // R11: strobes follow the wraps of the low channels by exactly one edge
    a_r11_strobe_tracks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (audio_stb == $past(ovf_w[AUDIO_TAPS-1:0])));

endmodule

// File: tb/tb_quad_interval_timer.sv
module tb_quad_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_clr = '0;
    logic [3:0]  irq_flag;
    logic [1:0]  audio_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_interval_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_clr   (irq_clr),
        .irq_flag  (irq_flag),
        .audio_stb (audio_stb)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_cnt [NT];
    int m_rel [NT];
    int m_ctl [NT];
    int m_psc [NT];
    bit m_irq [NT];
    bit m_stb [2];

    function automatic int period_of(int ctl);
        case (ctl & 3)
            0: return 1;
            1: return 64;
            2: return 256;
            default: return 1024;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NT; i++) begin
            m_cnt[i] = 0; m_rel[i] = 0; m_ctl[i] = 0; m_psc[i] = 0; m_irq[i] = 0;
        end
        m_stb[0] = 0; m_stb[1] = 0;
    endtask

    // Advances the model over one rising edge with the inputs now applied.
    task automatic model_step();
        bit ov [NT];
        for (int i = 0; i < NT; i++) begin
            int  c    = m_ctl[i];
            bit  run  = c[7];
            bit  ch   = c[2];
            bit  tick = 0;
            bit  inc  = 0;
            if (run && !ch) begin
                tick = (m_psc[i] == period_of(c) - 1);
                m_psc[i] = tick ? 0 : m_psc[i] + 1;
            end
            if (run) inc = ch ? ((i > 0) ? ov[i-1] : 1'b0) : tick;
            ov[i] = inc && (m_cnt[i] == 'hFFFF);
            if (ov[i]) m_cnt[i] = ch ? 0 : m_rel[i];
            else if (inc) m_cnt[i] = m_cnt[i] + 1;
            m_irq[i] = (m_irq[i] && !irq_clr[i]) || (ov[i] && c[6]);
            if (i < 2) m_stb[i] = ov[i];
            if (bus_wr_en && bus_addr == i[1:0]) begin
                int nc = int'(bus_wdata[31:16]);
                if (!c[7] && nc[7]) begin
                    m_cnt[i] = int'(bus_wdata[15:0]);
                    m_psc[i] = 0;
                end
                if ((nc & 3) != (c & 3)) m_psc[i] = 0;
                m_rel[i] = int'(bus_wdata[15:0]);
                m_ctl[i] = nc;
            end
        end
    endtask

    task automatic compare();
        int a = int'(bus_addr);
        check("R3 read word", bus_rdata, {m_ctl[a][15:0], m_cnt[a][15:0]});
        for (int i = 0; i < NT; i++) check("R9 irq flag", 32'(irq_flag[i]), 32'(m_irq[i]));
        for (int i = 0; i < 2; i++) check("R11 audio strobe", 32'(audio_stb[i]), 32'(m_stb[i]));
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        cyc();
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
        bus_addr = a;
        #1;
        check(tag, 32'(bus_rdata[15:0]), 32'(exp));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic [15:0] frozen;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every channel
        for (int i = 0; i < NT; i++) begin
            bus_addr = i[1:0];
            #1;
            check("R1 reset word", bus_rdata, 32'h0);
        end
        check("R1 reset flags", 32'(irq_flag), 32'h0);
        check("R1 reset strobes", 32'(audio_stb), 32'h0);

        // Channel 0 free-running at rate 0 with interrupt enable
        wr(2'd0, 32'h00C0_FFF0);
        rd(2'd0, 16'hFFF0, "R4 load on run rise");
        idle(15);
        rd(2'd0, 16'hFFFF, "R2 rate0 steps");
        cyc();
        rd(2'd0, 16'hFFF0, "R5 reload on wrap");
        check("R9 flag set", 32'(irq_flag[0]), 32'h1);
        check("R11 strobe high", 32'(audio_stb[0]), 32'h1);
        cyc();
        check("R11 strobe single cycle", 32'(audio_stb[0]), 32'h0);

        // R10: clear, then clear colliding with a wrap
        irq_clr = 4'b0001; cyc(); irq_clr = '0;
        check("R10 flag cleared", 32'(irq_flag[0]), 32'h0);
        idle(13);
        rd(2'd0, 16'hFFFF, "R2 count before wrap");
        irq_clr = 4'b0001; cyc(); irq_clr = '0;
        check("R10 wrap beats clear", 32'(irq_flag[0]), 32'h1);

        // R8: stop channel 0 and watch it hold
        wr(2'd0, 32'h0000_0000);
        bus_addr = 2'd0; #1; frozen = bus_rdata[15:0];
        idle(5);
        rd(2'd0, frozen, "R8 stopped holds");

        // R6, R7: chained ripple through channels 1 and 2
        wr(2'd1, 32'h0084_FFFE);
        wr(2'd2, 32'h00C4_FFFF);
        rd(2'd1, 16'hFFFE, "R6 chained idle");
        wr(2'd0, 32'h0080_FFFF);
        cyc();
        rd(2'd1, 16'hFFFF, "R6 chained step");
        cyc();
        rd(2'd1, 16'h0000, "R7 chained wrap to zero");
        rd(2'd2, 16'h0000, "R7 ripple same cycle");
        check("R9 chained flag", 32'(irq_flag[2]), 32'h1);
        check("R9 no flag without enable", 32'(irq_flag[1]), 32'h0);
        check("R11 both strobes", 32'(audio_stb), 32'h3);
        cyc();
        rd(2'd1, 16'h0001, "R7 continues from zero");

        // R6: channel 0 in chained mode never advances; R4 no reload while running
        wr(2'd0, 32'h0084_1234);
        rd(2'd0, 16'hFFFF, "R4 no reload on rewrite");
        idle(5);
        rd(2'd0, 16'hFFFF, "R6 channel 0 chained holds");
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h0000_0000);
        wr(2'd2, 32'h0000_0000);

        // R2, R12 on channel 3 at rates 1, 2, 3
        wr(2'd3, 32'h0081_FFFE);
        idle(63);
        rd(2'd3, 16'hFFFE, "R2 rate1 not yet");
        cyc();
        rd(2'd3, 16'hFFFF, "R2 rate1 step");
        wr(2'd3, 32'h0082_FFFE);
        idle(255);
        rd(2'd3, 16'hFFFF, "R12 rate change restarts");
        cyc();
        rd(2'd3, 16'hFFFE, "R5 rate2 wrap reload");
        wr(2'd3, 32'h0083_FFFE);
        idle(1023);
        rd(2'd3, 16'hFFFE, "R2 rate3 not yet");
        cyc();
        rd(2'd3, 16'hFFFF, "R2 rate3 step");
        wr(2'd3, 32'h0083_0100);
        rd(2'd3, 16'hFFFF, "R4 reload write keeps count");
        idle(1022);
        rd(2'd3, 16'hFFFF, "R2 rate3 before wrap");
        cyc();
        rd(2'd3, 16'h0100, "R5 uses new reload");

        // R12: rising run bit restarts the prescaler
        wr(2'd3, 32'h0003_0100);
        wr(2'd3, 32'hA581_FFF0);
        rd(2'd3, 16'hFFF0, "R4 reload on rise");
        check("R3 spare bits kept", 32'(bus_rdata[31:16]), 32'hA581);
        idle(63);
        rd(2'd3, 16'hFFF0, "R12 full period after run");
        cyc();
        rd(2'd3, 16'hFFF1, "R12 first step");

        // Mixed traffic against the model
        void'($urandom(7));
        for (int k = 0; k < 3000; k++) begin
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wr_en = ($urandom_range(0, 19) == 0);
            bus_wdata = {8'($urandom), ($urandom_range(0, 3) != 0), 1'($urandom),
                         3'($urandom), ($urandom_range(0, 3) == 0),
                         ($urandom_range(0, 7) == 0) ? 2'd1 : 2'd0,
                         ($urandom_range(0, 1) == 0) ? (16'hFFF0 | 16'($urandom_range(0, 15)))
                                                      : 16'($urandom)};
            irq_clr = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                       ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
            cyc();
        end
        bus_wr_en = 1'b0;
        irq_clr   = '0;
        idle(4);

        finish_run();
    end

endmodule